// File: doc/BRIEF.md
# Multi-Rank Request Scheduler with Early Write Completion

This block sits between a ring interface and sixteen memory ranks that each work on their own. Read and write requests arrive with a unique tag and a target rank. Each accepted request is marked live in a per-tag scoreboard and enters an ordered waiting list. Every cycle the scheduler scans the list from the oldest entry and sends the first request whose rank is idle and whose data is complete. A request that waits for a busy rank therefore never holds up younger work for other ranks, and several ranks can run at once.

Store data for a write arrives as a fixed number of beats, each beat carrying the write's tag. A write becomes eligible for dispatch only once all of its beats are buffered. Each rank stays busy from dispatch until it pulses its done line. Completion notices carry the tag back upstream through a registered valid/ready output. A mode input, sampled when each request is accepted, decides when a write reports complete. In late mode the notice waits for the rank to finish programming. In early mode the notice goes out as soon as the last store beat arrives. A tag stays reserved until its notice has been taken downstream.

Top module: `pcm_rank_sched`

## Requirements
- R1: After reset, disp_valid and cpl_valid are low and req_ready is high.
- R2: A request is accepted when req_valid and req_ready are both high. req_ready goes low once LIST_DEPTH (default 8) accepted requests are waiting for dispatch, and returns high when one leaves the list.
- R3: A tag stays outstanding from acceptance until its notice is taken (cpl_valid and cpl_ready both high). Upstream must not present an outstanding tag again.
- R4: At most one request is dispatched per cycle, and only to a rank that is idle. A rank is busy from its dispatch until its rank_done bit pulses. Requests to different ranks are dispatched without waiting for earlier ranks to finish.
- R5: A waiting request whose rank is busy does not block younger requests to idle ranks. Among the eligible requests, the oldest one is dispatched first.
- R6: A write is eligible for dispatch only after WBEATS (default 4) dat_valid beats with its tag have arrived. A read is eligible as soon as it is accepted.
- R7: A read produces its completion notice when rank_done pulses for the rank that holds it.
- R8: A write accepted with early_mode low produces its notice only when rank_done pulses for its rank.
- R9: A write accepted with early_mode high produces its notice once its last store beat arrives, even if its rank is still busy or it has not yet been dispatched. The later rank_done pulse for that write produces no notice.
- R10: early_mode is sampled at acceptance. Changing it afterwards does not change how an already accepted write completes.
- R11: Each tag gets exactly one notice. While cpl_ready is low, cpl_valid and cpl_tag hold. Notices that become due together are delivered lowest tag first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| early_mode | input | 1 | 1: writes complete on full data arrival; 0: on rank finish |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Waiting list has room |
| req_write | input | 1 | 1 for write, 0 for read |
| req_tag | input | 6 | Request tag |
| req_rank | input | 4 | Target rank |
| dat_valid | input | 1 | One store data beat |
| dat_tag | input | 6 | Tag of the write the beat belongs to |
| disp_valid | output | 1 | Dispatch pulse to a rank |
| disp_tag | output | 6 | Tag of dispatched request |
| disp_rank | output | 4 | Rank receiving the request |
| disp_write | output | 1 | Dispatched request is a write |
| rank_done | input | 16 | Per-rank finish pulse |
| cpl_valid | output | 1 | Completion notice available |
| cpl_ready | input | 1 | Downstream takes the notice |
| cpl_tag | output | 6 | Tag being completed |

## Verification
The bench targets a request stuck behind a busy rank. A design that blocks on it would stall the younger request for an idle rank, and a design without age order would release the younger of two waiting requests first. It sends an early-mode write whose rank is still occupied by a read. The notice must appear before dispatch, and nothing may follow the later rank finish. A design that sends notices from both sources would report that tag twice. The bench also flips the mode after acceptance, stops a write one beat short, holds cpl_ready low while notices pile up, and fills the waiting list. Each of these exposes a design that samples the mode late, dispatches on partial data, drops or reorders held notices, or accepts past its depth.

// File: rtl/pcm_sched_pkg.sv
package pcm_sched_pkg;
  localparam int unsigned TAGS   = 64;
  localparam int unsigned RANKS  = 16;
  localparam int unsigned TAG_W  = $clog2(TAGS);
  localparam int unsigned RANK_W = $clog2(RANKS);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [RANK_W-1:0] rank;
    logic              write;
    logic              ready;  // data complete (always 1 for reads)
    logic              note;   // rank finish yields a notice
  } req_ent_t;
endpackage

// File: rtl/sched_active_list.sv
module sched_active_list import pcm_sched_pkg::*; #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  req_ent_t         push_ent,
  output logic             full,
  input  logic             dat_done,
  input  logic [TAG_W-1:0] dat_done_tag,
  input  logic [RANKS-1:0] rank_busy,
  output logic             pop,
  output req_ent_t         pop_ent
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  req_ent_t         ent [DEPTH];
  req_ent_t         upd [DEPTH];
  req_ent_t         shf [DEPTH];
  logic [DEPTH-1:0] vld, vsh, elig;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    sel, wptr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      upd[i] = ent[i];
      if (dat_done && vld[i] && ent[i].write && ent[i].tag == dat_done_tag)
        upd[i].ready = 1'b1;
      elig[i] = vld[i] && ent[i].ready && !rank_busy[ent[i].rank];
    end
  end

  // oldest eligible entry: lowest index
  always_comb begin
    pop = 1'b0;
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) begin
        pop = 1'b1;
        sel = IW'(i);
      end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_shift
      if (g < DEPTH - 1) begin : g_mid
        assign shf[g] = upd[g+1];
        assign vsh[g] = vld[g+1];
      end else begin : g_top
        assign shf[g] = '0;
        assign vsh[g] = 1'b0;
      end
    end
  endgenerate

  assign pop_ent = ent[sel];
  assign full    = (cnt == CW'(DEPTH));
  assign wptr    = IW'(cnt - CW'(pop));

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      ent[i] <= (pop && i >= int'(sel)) ? shf[i] : upd[i];
    if (push) ent[wptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        vld[i] <= (pop && i >= int'(sel)) ? vsh[i] : vld[i];
      if (push) vld[wptr] <= 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  a_r2_push_room: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/sched_rank_table.sv
module sched_rank_table import pcm_sched_pkg::*; (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        disp,
  input  logic [RANK_W-1:0]           disp_rank,
  input  logic [TAG_W-1:0]            disp_tag,
  input  logic                        disp_note,
  input  logic [RANKS-1:0]            rank_done,
  output logic [RANKS-1:0]            busy,
  output logic [RANKS-1:0]            note,
  output logic [RANKS-1:0][TAG_W-1:0] rank_tag
);
  genvar r;
  generate
    for (r = 0; r < RANKS; r++) begin : g_rank
      logic hit, note_q;
      assign hit = disp && (disp_rank == RANK_W'(r));

      always_ff @(posedge clk) begin
        if (rst) busy[r] <= 1'b0;
        else if (hit) busy[r] <= 1'b1;
        else if (rank_done[r]) busy[r] <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (hit) begin
          rank_tag[r] <= disp_tag;
          note_q      <= disp_note;
        end
      end

      assign note[r] = rank_done[r] && busy[r] && note_q;
    end
  endgenerate

  a_r4_idle_target: assert property (@(posedge clk) disable iff (rst)
    disp |-> !busy[disp_rank]);
  a_r4_done_when_busy: assert property (@(posedge clk) disable iff (rst)
    (rank_done & ~busy) == '0);
endmodule

// File: rtl/sched_scoreboard.sv
module sched_scoreboard import pcm_sched_pkg::*; #(
  parameter int unsigned WBEATS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        acc,
  input  logic [TAG_W-1:0]            acc_tag,
  input  logic                        acc_early,
  input  logic                        dat_valid,
  input  logic [TAG_W-1:0]            dat_tag,
  output logic                        dat_done,
  input  logic [RANKS-1:0]            rank_note,
  input  logic [RANKS-1:0][TAG_W-1:0] rank_tag,
  output logic                        cpl_valid,
  input  logic                        cpl_ready,
  output logic [TAG_W-1:0]            cpl_tag
);
  localparam int unsigned BW = (WBEATS > 1) ? $clog2(WBEATS) : 1;

  logic [BW-1:0]    beats [TAGS];
  logic [TAGS-1:0]  early, live, pend, pend_set, clr;
  logic             any, load, take;
  logic [TAG_W-1:0] idx;

  assign dat_done = dat_valid && (beats[dat_tag] == BW'(WBEATS - 1));
  assign take     = cpl_valid && cpl_ready;
  assign load     = !cpl_valid || cpl_ready;

  always_ff @(posedge clk) begin
    if (acc) begin
      beats[acc_tag] <= '0;
      early[acc_tag] <= acc_early;
    end
    if (dat_valid) beats[dat_tag] <= dat_done ? '0 : beats[dat_tag] + 1'b1;
  end

  always_comb begin
    pend_set = '0;
    for (int r = 0; r < RANKS; r++)
      if (rank_note[r]) pend_set[rank_tag[r]] = 1'b1;
    if (dat_done && early[dat_tag]) pend_set[dat_tag] = 1'b1;
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int t = TAGS - 1; t >= 0; t--)
      if (pend[t]) begin
        any = 1'b1;
        idx = TAG_W'(t);
      end
    clr = '0;
    if (load && any) clr[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= '0;
      pend      <= '0;
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
    end else begin
      pend <= (pend & ~clr) | pend_set;
      if (take) live[cpl_tag] <= 1'b0;
      if (acc)  live[acc_tag] <= 1'b1;
      if (load) begin
        cpl_valid <= any;
        cpl_tag   <= idx;
      end
    end
  end

  a_r3_unique_tag: assert property (@(posedge clk) disable iff (rst)
    acc |-> !live[acc_tag]);
  a_r11_notice_live: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> live[cpl_tag]);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag));
  a_r11_single_notice: assert property (@(posedge clk) disable iff (rst)
    (pend_set & pend) == '0);
  a_r6_beat_live: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> live[dat_tag]);
endmodule

// File: rtl/pcm_rank_sched.sv
module pcm_rank_sched import pcm_sched_pkg::*; #(
  parameter int unsigned LIST_DEPTH = 8,
  parameter int unsigned WBEATS     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              early_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              dat_valid,
  input  logic [TAG_W-1:0]  dat_tag,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [RANK_W-1:0] disp_rank,
  output logic              disp_write,
  input  logic [RANKS-1:0]  rank_done,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag
);
  logic                        full, push, dat_done, pop;
  req_ent_t                    push_ent, pop_ent;
  logic [RANKS-1:0]            busy, note;
  logic [RANKS-1:0][TAG_W-1:0] rank_tag;

  assign req_ready = !full;
  assign push      = req_valid && !full;
  assign push_ent  = '{tag: req_tag, rank: req_rank, write: req_write,
                       ready: !req_write, note: !req_write || !early_mode};

  sched_active_list #(.DEPTH(LIST_DEPTH)) u_list (
    .clk, .rst, .push, .push_ent, .full,
    .dat_done, .dat_done_tag(dat_tag),
    .rank_busy(busy), .pop, .pop_ent
  );

  sched_rank_table u_ranks (
    .clk, .rst, .disp(pop), .disp_rank(pop_ent.rank), .disp_tag(pop_ent.tag),
    .disp_note(pop_ent.note), .rank_done, .busy, .note, .rank_tag
  );

  sched_scoreboard #(.WBEATS(WBEATS)) u_sb (
    .clk, .rst, .acc(push), .acc_tag(req_tag), .acc_early(early_mode),
    .dat_valid, .dat_tag, .dat_done, .rank_note(note), .rank_tag,
    .cpl_valid, .cpl_ready, .cpl_tag
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_tag   <= '0;
      disp_rank  <= '0;
      disp_write <= 1'b0;
    end else begin
      disp_valid <= pop;
      disp_tag   <= pop_ent.tag;
      disp_rank  <= pop_ent.rank;
      disp_write <= pop_ent.write;
    end
  end

  a_r4_one_dispatch_per_rank: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> busy[disp_rank]);
endmodule

// File: tb/pcm_rank_sched_bench.sv
module pcm_rank_sched_bench;
  import pcm_sched_pkg::*;

  logic clk = 0, rst = 1, early_mode = 0;
  logic req_valid = 0, req_write = 0, dat_valid = 0, cpl_ready = 1;
  logic [TAG_W-1:0] req_tag = '0, dat_tag = '0;
  logic [RANK_W-1:0] req_rank = '0;
  logic [RANKS-1:0] rank_done = '0;
  logic req_ready, disp_valid, disp_write, cpl_valid;
  logic [TAG_W-1:0] disp_tag, cpl_tag;
  logic [RANK_W-1:0] disp_rank;

  int checks = 0, errors = 0;
  int dn = 0, cn = 0;
  logic [TAG_W-1:0]  dtag [256];
  logic [RANK_W-1:0] drank [256];
  logic [TAG_W-1:0]  ctag [256];
  bit done_flag = 0;

  always #10 clk = ~clk;

  pcm_rank_sched u_pcm_rank_sched (.*);

  always @(posedge clk) begin
    if (!rst) begin
      if (disp_valid) begin dtag[dn] = disp_tag; drank[dn] = disp_rank; dn++; end
      if (cpl_valid && cpl_ready) begin ctag[cn] = cpl_tag; cn++; end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic send(int t, int r, bit w);
    req_valid = 1; req_tag = TAG_W'(t); req_rank = RANK_W'(r); req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic beats(int t, int n);
    for (int k = 0; k < n; k++) begin
      dat_valid = 1; dat_tag = TAG_W'(t);
      @(negedge clk);
      dat_valid = 0;
    end
  endtask

  task automatic done(logic [RANKS-1:0] m);
    rank_done = m;
    @(negedge clk);
    rank_done = '0;
  endtask

  // {tag[5:0], rank[3:0]} read vectors
  localparam logic [9:0] VEC [6] = '{
    {6'd1, 4'd0}, {6'd2, 4'd15}, {6'd3, 4'd7},
    {6'd4, 4'd0}, {6'd5, 4'd9},  {6'd6, 4'd3}};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0, c0;
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    check(disp_valid == 0, "R1 disp_valid", disp_valid, 0);
    check(cpl_valid == 0, "R1 cpl_valid", cpl_valid, 0);
    check(req_ready == 1, "R1 req_ready", req_ready, 1);

    // table walk: R4 dispatch, R7 read completion
    foreach (VEC[i]) begin
      d0 = dn; c0 = cn;
      send(VEC[i][9:4], VEC[i][3:0], 0);
      cyc(4);
      check(dn == d0 + 1 && dtag[d0] == VEC[i][9:4] && drank[d0] == VEC[i][3:0],
            "R4 dispatch tag", int'(dtag[d0]), int'(VEC[i][9:4]));
      done(RANKS'(1) << VEC[i][3:0]);
      cyc(4);
      check(cn == c0 + 1 && ctag[c0] == VEC[i][9:4], "R7 read completion",
            int'(ctag[c0]), int'(VEC[i][9:4]));
    end

    // R4 parallel ranks, R11 lowest tag first
    d0 = dn; c0 = cn;
    send(8, 1, 0); send(9, 2, 0); send(10, 3, 0);
    cyc(5);
    check(dn == d0 + 3, "R4 parallel dispatch count", dn - d0, 3);
    done(16'h000E);
    cyc(6);
    check(cn == c0 + 3 && ctag[c0] == 8 && ctag[c0+1] == 9 && ctag[c0+2] == 10,
          "R11 order of joint notices", int'(ctag[c0]), 8);

    // R5 busy rank does not block
    d0 = dn; c0 = cn;
    send(11, 5, 0); send(12, 5, 0); send(13, 6, 0);
    cyc(5);
    check(dn == d0 + 2 && dtag[d0+1] == 13, "R5 younger to idle rank goes",
          int'(dtag[d0+1]), 13);
    done(16'h0020);
    cyc(4);
    check(dn == d0 + 3 && dtag[d0+2] == 12, "R5 waiting one follows",
          int'(dtag[d0+2]), 12);
    done(16'h0060);
    cyc(5);
    check(cn == c0 + 3, "R7 three reads complete", cn - c0, 3);

    // R5 oldest first among same rank
    d0 = dn;
    send(14, 8, 0); cyc(3);
    send(15, 8, 0); send(16, 8, 0);
    cyc(3);
    done(16'h0100);
    cyc(4);
    check(dn == d0 + 2 && dtag[d0+1] == 15, "R5 oldest first",
          int'(dtag[d0+1]), 15);
    done(16'h0100); cyc(4);
    check(dn == d0 + 3 && dtag[d0+2] == 16, "R5 second oldest",
          int'(dtag[d0+2]), 16);
    done(16'h0100); cyc(4);

    // R6 data gating, R8 late write
    early_mode = 0;
    d0 = dn; c0 = cn;
    send(20, 4, 1);
    beats(20, 3);
    cyc(4);
    check(dn == d0, "R6 no dispatch on partial data", dn - d0, 0);
    beats(20, 1);
    cyc(4);
    check(dn == d0 + 1 && dtag[d0] == 20, "R6 dispatch after full data",
          int'(dtag[d0]), 20);
    check(cn == c0, "R8 late write waits for rank", cn - c0, 0);
    done(16'h0010);
    cyc(4);
    check(cn == c0 + 1 && ctag[c0] == 20, "R8 late write completes",
          int'(ctag[c0]), 20);

    // R9 early write
    early_mode = 1;
    c0 = cn;
    send(21, 10, 1);
    beats(21, 4);
    cyc(4);
    check(cn == c0 + 1 && ctag[c0] == 21, "R9 early notice", int'(ctag[c0]), 21);
    done(16'h0400);
    cyc(5);
    check(cn == c0 + 1, "R9 no notice on rank finish", cn - c0, 1);

    // R9 early notice before dispatch, rank occupied by a read
    send(22, 11, 0);
    cyc(3);
    d0 = dn; c0 = cn;
    send(23, 11, 1);
    beats(23, 4);
    cyc(4);
    check(cn == c0 + 1 && ctag[c0] == 23, "R9 notice ahead of dispatch",
          int'(ctag[c0]), 23);
    check(dn == d0, "R9 write still waiting", dn - d0, 0);
    done(16'h0800);
    cyc(4);
    check(dn == d0 + 1 && dtag[d0] == 23, "R4 write dispatched after read",
          int'(dtag[d0]), 23);
    done(16'h0800);
    cyc(5);
    check(cn == c0 + 2 && ctag[c0+1] == 22, "R11 one notice each",
          cn - c0, 2);

    // R10 mode sampled at acceptance
    early_mode = 0;
    c0 = cn;
    send(24, 12, 1);
    early_mode = 1;
    beats(24, 4);
    cyc(5);
    check(cn == c0, "R10 late write ignores mode change", cn - c0, 0);
    done(16'h1000);
    cyc(4);
    check(cn == c0 + 1 && ctag[c0] == 24, "R10 completes on rank finish",
          int'(ctag[c0]), 24);
    early_mode = 0;

    // R11 hold while not ready
    cpl_ready = 0;
    c0 = cn;
    send(25, 13, 0); send(26, 2, 0);
    cyc(4);
    done(16'h2004);
    cyc(4);
    check(cpl_valid == 1 && cpl_tag == 25, "R11 held notice", int'(cpl_tag), 25);
    cyc(3);
    check(cpl_valid == 1 && cpl_tag == 25, "R11 still held", int'(cpl_tag), 25);
    cpl_ready = 1;
    cyc(4);
    check(cn == c0 + 2 && ctag[c0] == 25 && ctag[c0+1] == 26,
          "R11 release order", cn - c0, 2);

    // R2 list full
    c0 = cn;
    send(30, 14, 0);
    cyc(3);
    for (int k = 0; k < 8; k++) send(31 + k, 14, 0);
    check(req_ready == 0, "R2 ready low when full", req_ready, 0);
    for (int k = 0; k < 9; k++) begin
      done(16'h4000);
      cyc(3);
    end
    cyc(3);
    check(req_ready == 1, "R2 ready back", req_ready, 1);
    check(cn == c0 + 9, "R3 all queued complete", cn - c0, 9);
    check(disp_valid == 0 && cpl_valid == 0, "R4 idle at end", cpl_valid, 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule